// File: doc/BRIEF.md
# Reorder Buffer Commit Unit

This block keeps the program order of in-flight instructions in a speculative out-of-order core. It is a circular buffer with a head pointer and a tail pointer. At issue, an instruction takes the slot at the tail, and the slot index goes back to the issue logic as the destination tag. The issue logic only issues when a slot is free and a reservation station is also free; the reservation stations sit outside this block.

Results come back over the common data bus in any order. Each result is stored in the slot named by its tag, and nothing architectural changes at that point. Retirement happens only at the head and strictly in order. Up to two entries can leave per cycle: a register write, a store, or a branch. Each retiring lane is shown on the commit port, and the register file or store logic outside performs the update.

When a branch that resolved as mispredicted reaches the head, it retires and the block raises a flush in the same cycle. Every younger entry is discarded, and the buffer is empty from the next cycle.

Top module: `rob_commit_unit`

## Requirements
- R1: After reset the buffer is empty: `allocReady` is 1, `allocTag` is 0, `commitVld` is 0 and `flushOut` is 0.
- R2: An allocation is taken on a clock edge where `allocReq` and `allocReady` are both 1 and no flush is active. Taken allocations receive tags 0, 1, 2 and so on, wrapping modulo DEPTH, in request order. `allocTag` shows the tag the next allocation will receive.
- R3: While DEPTH entries are held, `allocReady` is 0 and an `allocReq` has no effect: the tag handed out after the buffer drains is the one that was pending before the ignored request.
- R4: A result written with `cdbValid` and `cdbTag` marks that entry ready. Results may arrive in any order, and a ready entry produces no commit while an older entry ahead of it is still waiting.
- R5: When the head entry is ready, commit lane 0 shows it in the cycle after its result was written, and the entry leaves at the next edge. Entries commit in allocation order, each with the kind, destination and value that were recorded for it.
- R6: If the entry behind the head is also ready, it commits on lane 1 in the same cycle. Lane 1 (`commitVld[1]`) is never active without lane 0.
- R7: A head entry of kind branch whose result carried `cdbMispredict`=1 commits with `flushOut`=1. No younger entry ever commits. An allocation requested in that cycle is ignored. In the next cycle the buffer is empty and the next tag is the one after the branch.
- R8: When lane 0 flushes, lane 1 does not commit. When lane 1 holds a mispredicted branch, lane 0 commits, then lane 1 commits with the flush.
- R9: Kind encoding is 2'b00 register write, 2'b01 store and 2'b10 branch. The kind of lane n is `commitKind[2n+1:2n]`. A correctly predicted branch retires with its kind shown and no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| allocReq | input | 1 | Request a slot for the next instruction in program order |
| allocKind | input | 2 | Kind of the instruction being allocated |
| allocDest | input | DEST_W | Destination register number or store slot |
| allocReady | output | 1 | A free slot exists |
| allocTag | output | IDX_W | Tag the next allocation receives |
| cdbValid | input | 1 | Result broadcast present |
| cdbTag | input | IDX_W | Tag of the entry the result belongs to |
| cdbData | input | DATA_W | Result value |
| cdbMispredict | input | 1 | For a branch: resolved as mispredicted |
| commitVld | output | 2 | Per-lane commit strobe |
| commitKind | output | 4 | Kind per lane, 2 bits each |
| commitDest | output | 2*DEST_W | Destination per lane |
| commitData | output | 2*DATA_W | Value per lane |
| flushOut | output | 1 | Mispredicted branch retiring: discard all younger work |

## Verification
The hardest situations to reach are those where the two commit lanes interact with a flush. One is a mispredicted branch on lane 0 while the entry behind it is already ready. The other is a mispredicted branch on lane 1 behind a ready head. To reach either, the stimulus writes results out of order: the younger entries first, the branch next, and the head last, so that both lanes become ready on the same edge. A full buffer with a refused request, followed by a tag check after draining, shows that the pointers did not move. A scoreboard drops its pending items whenever a flush is expected, so any squashed entry that still commits is reported.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_REG    = 2'b00,
    KIND_STORE  = 2'b01,
    KIND_BRANCH = 2'b10
  } robKind_e;

  // strobes from control to the entry storage
  typedef struct packed {
    logic allocEn;
    logic retire0;
    logic retire1;
    logic flushAll;
  } robStrobe_t;
endpackage

// File: rtl/rob_store.sv
module rob_store
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3,
  parameter int DEST_W = 5,
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  robStrobe_t                  strb,
  input  logic [IDX_W-1:0]            allocIdx,
  input  logic [1:0]                  allocKind,
  input  logic [DEST_W-1:0]           allocDest,
  input  logic [IDX_W-1:0]            headIdx,
  input  logic [IDX_W-1:0]            nextIdx,
  input  logic                        cdbValid,
  input  logic [IDX_W-1:0]            cdbTag,
  input  logic [DATA_W-1:0]           cdbData,
  input  logic                        cdbMispredict,
  output logic [1:0]                  hValid,
  output logic [1:0]                  hReady,
  output logic [1:0]                  hMisp,
  output logic [1:0][1:0]             hKind,
  output logic [1:0][DEST_W-1:0]      hDest,
  output logic [1:0][DATA_W-1:0]      hData
);
  logic [DEPTH-1:0]             entValid;
  logic [DEPTH-1:0]             entReady;
  logic [DEPTH-1:0]             entMisp;
  logic [DEPTH-1:0][1:0]        entKind;
  logic [DEPTH-1:0][DEST_W-1:0] entDest;
  logic [DEPTH-1:0][DATA_W-1:0] entData;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic hitAlloc, hitCdb, hitRetire;
    assign hitAlloc  = strb.allocEn && (allocIdx == IDX_W'(i));
    assign hitCdb    = cdbValid && (cdbTag == IDX_W'(i)) && entValid[i];
    assign hitRetire = (strb.retire0 && (headIdx == IDX_W'(i))) ||
                       (strb.retire1 && (nextIdx == IDX_W'(i)));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entValid[i] <= 1'b0;
        entReady[i] <= 1'b0;
        entMisp[i]  <= 1'b0;
      end else if (strb.flushAll) begin
        entValid[i] <= 1'b0;
      end else begin
        if (hitRetire) entValid[i] <= 1'b0;
        if (hitAlloc) begin
          entValid[i] <= 1'b1;
          entReady[i] <= 1'b0;
          entMisp[i]  <= 1'b0;
        end
        if (hitCdb) begin
          entReady[i] <= 1'b1;
          entMisp[i]  <= cdbMispredict;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (hitAlloc) begin
        entKind[i] <= allocKind;
        entDest[i] <= allocDest;
      end
      if (hitCdb && !strb.flushAll) entData[i] <= cdbData;
    end
  end

  always_comb begin
    hValid = {entValid[nextIdx], entValid[headIdx]};
    hReady = {entReady[nextIdx], entReady[headIdx]};
    hMisp  = {entMisp[nextIdx],  entMisp[headIdx]};
    hKind  = {entKind[nextIdx],  entKind[headIdx]};
    hDest  = {entDest[nextIdx],  entDest[headIdx]};
    hData  = {entData[nextIdx],  entData[headIdx]};
  end
endmodule

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             allocReq,
  input  logic [1:0]       hValid,
  input  logic [1:0]       hReady,
  input  logic [1:0]       hMisp,
  input  logic [1:0][1:0]  hKind,
  output robStrobe_t       strb,
  output logic [IDX_W-1:0] allocIdx,
  output logic [IDX_W-1:0] headIdx,
  output logic [IDX_W-1:0] nextIdx,
  output logic             allocReady,
  output logic [1:0]       commitVld,
  output logic             flushOut
);
  localparam int PTR_W = IDX_W + 1;

  logic [PTR_W-1:0] headPtr, tailPtr, used, retireCnt, newHead;
  logic             full, fire0, fire1, flush0, flush1, flushAny;

  assign used     = tailPtr - headPtr;
  assign full     = (used == PTR_W'(DEPTH));
  assign headIdx  = headPtr[IDX_W-1:0];
  assign nextIdx  = headIdx + IDX_W'(1);
  assign allocIdx = tailPtr[IDX_W-1:0];

  always_comb begin
    fire0     = hValid[0] && hReady[0];
    flush0    = fire0 && (hKind[0] == KIND_BRANCH) && hMisp[0];
    fire1     = fire0 && !flush0 && hValid[1] && hReady[1];
    flush1    = fire1 && (hKind[1] == KIND_BRANCH) && hMisp[1];
    flushAny  = flush0 || flush1;
    retireCnt = PTR_W'(fire0) + PTR_W'(fire1);
    newHead   = headPtr + retireCnt;
  end

  always_comb begin
    strb.allocEn  = allocReq && !full && !flushAny;
    strb.retire0  = fire0;
    strb.retire1  = fire1;
    strb.flushAll = flushAny;
  end

  assign allocReady = !full;
  assign commitVld  = {fire1, fire0};
  assign flushOut   = flushAny;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else begin
      headPtr <= newHead;
      if (flushAny)          tailPtr <= newHead;
      else if (strb.allocEn) tailPtr <= tailPtr + PTR_W'(1);
    end
  end
endmodule

// File: rtl/rob_commit_unit.sv
module rob_commit_unit
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DEST_W = 5,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  allocReq,
  input  logic [1:0]            allocKind,
  input  logic [DEST_W-1:0]     allocDest,
  output logic                  allocReady,
  output logic [IDX_W-1:0]      allocTag,
  input  logic                  cdbValid,
  input  logic [IDX_W-1:0]      cdbTag,
  input  logic [DATA_W-1:0]     cdbData,
  input  logic                  cdbMispredict,
  output logic [1:0]            commitVld,
  output logic [3:0]            commitKind,
  output logic [2*DEST_W-1:0]   commitDest,
  output logic [2*DATA_W-1:0]   commitData,
  output logic                  flushOut
);
  robStrobe_t               strb;
  logic [IDX_W-1:0]         headIdx, nextIdx;
  logic [1:0]               hValid, hReady, hMisp;
  logic [1:0][1:0]          hKind;
  logic [1:0][DEST_W-1:0]   hDest;
  logic [1:0][DATA_W-1:0]   hData;

  rob_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .allocReq(allocReq),
    .hValid(hValid), .hReady(hReady), .hMisp(hMisp), .hKind(hKind),
    .strb(strb), .allocIdx(allocTag), .headIdx(headIdx), .nextIdx(nextIdx),
    .allocReady(allocReady), .commitVld(commitVld), .flushOut(flushOut)
  );

  rob_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .DEST_W(DEST_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rstN(rstN), .strb(strb),
    .allocIdx(allocTag), .allocKind(allocKind), .allocDest(allocDest),
    .headIdx(headIdx), .nextIdx(nextIdx),
    .cdbValid(cdbValid), .cdbTag(cdbTag), .cdbData(cdbData), .cdbMispredict(cdbMispredict),
    .hValid(hValid), .hReady(hReady), .hMisp(hMisp),
    .hKind(hKind), .hDest(hDest), .hData(hData)
  );

  assign commitKind = hKind;
  assign commitDest = hDest;
  assign commitData = hData;
endmodule

// File: rtl/rob_commit_unit_chk.sv
module rob_commit_unit_chk #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             allocReq,
  input logic             allocReady,
  input logic [IDX_W-1:0] allocTag,
  input logic [1:0]       commitVld,
  input logic [3:0]       commitKind,
  input logic             flushOut
);
  localparam int PTR_W = IDX_W + 1;

  logic [PTR_W-1:0] occ, hdModel, tlModel, ret, acc;

  assign ret = PTR_W'(commitVld[0]) + PTR_W'(commitVld[1]);
  assign acc = PTR_W'(allocReq && allocReady && !flushOut);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      occ <= '0; hdModel <= '0; tlModel <= '0;
    end else if (flushOut) begin
      occ <= '0;
      hdModel <= hdModel + ret;
      tlModel <= hdModel + ret;
    end else begin
      occ <= occ + acc - ret;
      hdModel <= hdModel + ret;
      tlModel <= tlModel + acc;
    end
  end

  // R3
  full_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    allocReady == (occ != PTR_W'(DEPTH)));
  // R2
  tag_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    allocReady |-> allocTag == tlModel[IDX_W-1:0]);
  // R6
  lane_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitVld[1] |-> commitVld[0]);
  // R5
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (occ == '0) |-> (commitVld == 2'b00));
  // R7
  flush_branch_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushOut |-> (commitVld[0] && ((commitVld[1] ? commitKind[3:2] : commitKind[1:0]) == 2'b10)));
  // R7
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushOut |=> (commitVld == 2'b00 && allocReady));
endmodule

bind rob_commit_unit rob_commit_unit_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .allocReq(allocReq), .allocReady(allocReady),
  .allocTag(allocTag), .commitVld(commitVld), .commitKind(commitKind), .flushOut(flushOut)
);

// File: tb/rob_commit_unit_tb.sv
module rob_commit_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int IDX_W = 3;
  localparam int DEST_W = 5;
  localparam int DATA_W = 32;
  localparam logic [1:0] K_REG = 2'b00, K_ST = 2'b01, K_BR = 2'b10;

  logic clk = 1'b0, rstN = 1'b0;
  logic allocReq = 1'b0;
  logic [1:0] allocKind = '0;
  logic [DEST_W-1:0] allocDest = '0;
  logic allocReady;
  logic [IDX_W-1:0] allocTag;
  logic cdbValid = 1'b0;
  logic [IDX_W-1:0] cdbTag = '0;
  logic [DATA_W-1:0] cdbData = '0;
  logic cdbMispredict = 1'b0;
  logic [1:0] commitVld;
  logic [3:0] commitKind;
  logic [2*DEST_W-1:0] commitDest;
  logic [2*DATA_W-1:0] commitData;
  logic flushOut;

  rob_commit_unit #(.DEPTH(DEPTH), .DEST_W(DEST_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rstN(rstN), .allocReq(allocReq), .allocKind(allocKind),
    .allocDest(allocDest), .allocReady(allocReady), .allocTag(allocTag),
    .cdbValid(cdbValid), .cdbTag(cdbTag), .cdbData(cdbData),
    .cdbMispredict(cdbMispredict), .commitVld(commitVld), .commitKind(commitKind),
    .commitDest(commitDest), .commitData(commitData), .flushOut(flushOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int tag;
    logic [1:0] kind;
    logic [DEST_W-1:0] dest;
  } exp_t;

  exp_t expQ[$];
  logic [DATA_W-1:0] expData [DEPTH];
  bit expMisp [DEPTH];
  int checks = 0, fails = 0, nextTag = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doAlloc(input logic [1:0] k, input logic [DEST_W-1:0] d);
    exp_t it;
    @(negedge clk);
    chk(allocReady == 1'b1, "R2", "allocReady", allocReady, 1);
    chk(int'(allocTag) == nextTag, "R2", "allocTag", allocTag, nextTag);
    allocReq = 1'b1; allocKind = k; allocDest = d;
    it.tag = nextTag; it.kind = k; it.dest = d;
    expQ.push_back(it);
    @(posedge clk); #1;
    allocReq = 1'b0;
    nextTag = (nextTag + 1) % DEPTH;
  endtask

  task automatic tryAlloc();
    @(negedge clk);
    allocReq = 1'b1; allocKind = K_REG; allocDest = 5'd31;
    @(posedge clk); #1;
    allocReq = 1'b0;
  endtask

  task automatic doCdb(input int t, input logic [DATA_W-1:0] v, input bit m);
    @(negedge clk);
    cdbValid = 1'b1; cdbTag = IDX_W'(t); cdbData = v; cdbMispredict = m;
    expData[t] = v; expMisp[t] = m;
    @(posedge clk); #1;
    cdbValid = 1'b0; cdbMispredict = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: R5 order and payload, R7/R8 flush behaviour
  always @(negedge clk) begin
    if (rstN && (commitVld != 2'b00 || flushOut)) begin
      exp_t it0, it1;
      bit f0, f1;
      if (!commitVld[0]) begin
        chk(1'b0, "R6", "lane1/flush without lane0", commitVld, 1);
      end else if (expQ.size() == 0) begin
        chk(1'b0, "R5", "unexpected commit", commitVld, 0);
      end else begin
        it0 = expQ.pop_front();
        chk(commitKind[1:0] == it0.kind, "R5", "lane0 kind", commitKind[1:0], it0.kind);
        chk(commitDest[DEST_W-1:0] == it0.dest, "R5", "lane0 dest", commitDest[DEST_W-1:0], it0.dest);
        chk(commitData[DATA_W-1:0] == expData[it0.tag], "R5", "lane0 data",
            commitData[DATA_W-1:0], expData[it0.tag]);
        f0 = (it0.kind == K_BR) && expMisp[it0.tag];
        if (f0) begin
          chk(commitVld[1] == 1'b0, "R8", "lane1 after lane0 flush", commitVld[1], 0);
          chk(flushOut == 1'b1, "R7", "flushOut", flushOut, 1);
          expQ.delete();
        end else if (commitVld[1]) begin
          if (expQ.size() == 0) begin
            chk(1'b0, "R6", "unexpected lane1 commit", commitVld, 1);
          end else begin
            it1 = expQ.pop_front();
            chk(commitKind[3:2] == it1.kind, "R6", "lane1 kind", commitKind[3:2], it1.kind);
            chk(commitDest[2*DEST_W-1:DEST_W] == it1.dest, "R6", "lane1 dest",
                commitDest[2*DEST_W-1:DEST_W], it1.dest);
            chk(commitData[2*DATA_W-1:DATA_W] == expData[it1.tag], "R6", "lane1 data",
                commitData[2*DATA_W-1:DATA_W], expData[it1.tag]);
            f1 = (it1.kind == K_BR) && expMisp[it1.tag];
            chk(flushOut == f1, "R8", "flushOut lane1", flushOut, f1);
            if (f1) expQ.delete();
          end
        end else begin
          chk(flushOut == 1'b0, "R9", "flush without mispredict", flushOut, 0);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(allocReady == 1'b1, "R1", "allocReady", allocReady, 1);
    chk(allocTag == '0, "R1", "allocTag", allocTag, 0);
    chk(commitVld == 2'b00, "R1", "commitVld", commitVld, 0);
    chk(flushOut == 1'b0, "R1", "flushOut", flushOut, 0);

    // out-of-order results, dual commit
    doAlloc(K_REG, 5'd3);
    doAlloc(K_REG, 5'd7);
    doAlloc(K_ST, 5'd9);
    doCdb(2, 32'hC0DE_0002, 1'b0);
    doCdb(1, 32'hC0DE_0001, 1'b0);
    @(negedge clk);
    chk(commitVld == 2'b00, "R4", "younger ready, head waiting", commitVld, 0);
    doCdb(0, 32'hC0DE_0000, 1'b0);
    @(negedge clk);
    chk(commitVld == 2'b11, "R6", "two lanes commit", commitVld, 3);
    idle(3);

    // correctly predicted branch
    doAlloc(K_BR, 5'd0);
    doAlloc(K_ST, 5'd4);
    doCdb(3, 32'h0000_0BB0, 1'b0);
    @(negedge clk);
    chk(commitVld == 2'b01 && commitKind[1:0] == K_BR && !flushOut, "R9",
        "branch retire no flush", {commitVld, commitKind[1:0], flushOut}, {2'b01, K_BR, 1'b0});
    doCdb(4, 32'h5705_0004, 1'b0);
    idle(3);

    // fill to capacity
    for (int i = 0; i < DEPTH; i++) doAlloc(K_REG, DEST_W'(i + 1));
    @(negedge clk);
    chk(allocReady == 1'b0, "R3", "allocReady when full", allocReady, 0);
    tryAlloc();
    for (int i = 0; i < DEPTH; i++) doCdb((5 + i) % DEPTH, DATA_W'(32'hF000 + i), 1'b0);
    idle(4);
    chk(allocReady == 1'b1, "R3", "allocReady after drain", allocReady, 1);

    // mispredict at head on lane 0
    doAlloc(K_REG, 5'd10);   // tag 5; allocTag check here covers R3 ignored request
    doAlloc(K_BR, 5'd0);     // tag 6
    doAlloc(K_REG, 5'd11);   // tag 7
    doAlloc(K_REG, 5'd12);   // tag 0
    doCdb(7, 32'h0000_0777, 1'b0);
    doCdb(0, 32'h0000_0888, 1'b0);
    doCdb(5, 32'h0000_0555, 1'b0);
    doCdb(6, 32'h0000_0666, 1'b1);
    tryAlloc();              // flush cycle: ignored
    @(negedge clk);
    chk(commitVld == 2'b00, "R7", "squashed entries quiet", commitVld, 0);
    chk(allocReady == 1'b1, "R7", "empty after flush", allocReady, 1);
    nextTag = 7;

    // R8: lane0 flushes while lane1 ready
    doAlloc(K_BR, 5'd0);     // tag 7
    doAlloc(K_REG, 5'd13);   // tag 0
    doCdb(0, 32'h0000_1300, 1'b0);
    doCdb(7, 32'h0000_0B07, 1'b1);
    @(negedge clk);
    chk(commitVld == 2'b01 && flushOut, "R8", "lane0 flush blocks lane1",
        {commitVld, flushOut}, 3'b011);
    nextTag = 0;
    idle(1);

    // R8: mispredicted branch on lane 1
    doAlloc(K_REG, 5'd14);   // tag 0
    doAlloc(K_BR, 5'd0);     // tag 1
    doAlloc(K_REG, 5'd15);   // tag 2
    doCdb(2, 32'h0000_1500, 1'b0);
    doCdb(1, 32'h0000_0B01, 1'b1);
    doCdb(0, 32'h0000_1400, 1'b0);
    @(negedge clk);
    chk(commitVld == 2'b11 && flushOut, "R8", "lane1 flush after lane0",
        {commitVld, flushOut}, 3'b111);
    nextTag = 2;

    doAlloc(K_ST, 5'd20);    // tag 2 follows the branch
    doCdb(2, 32'h0000_2020, 1'b0);
    idle(3);
    chk(expQ.size() == 0, "R5", "all expected commits seen", expQ.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule